// File: doc/BRIEF.md
# ECC Error Pending-Count Status

This block keeps the interrupt bookkeeping for a set of ECC checkers. Four saturating 2-bit counters each record how many error interrupts of one class are still waiting for service. The classes are corrected, uncorrected, injected-corrected and injected-uncorrected. The checkers raise one pulse per error on a per-class event line. Each pulse also presents three 16-bit details: the reporting checker's group, the error type and the faulting bit. The block latches the details of the most recent event.

Software uses a single write port. Every write adds the value in each class's add field to that class's counter and subtracts the value in its matching clear field, so one write can adjust all four counters. A read port returns the four counts twice: once in the add-field positions and once, mirrored, in the clear-field positions. A level interrupt stays high while any count is non-zero.

Top module: `ecc_pend_status`

## Requirements
- R1: After reset all four counts, the captured group, type and bit fields, and `irq` are 0.
- R2: A pulse on `evt_hit[k]` raises counter k by one on the next clock edge. Class index k is 0 for corrected, 1 for uncorrected, 2 for injected-corrected and 3 for injected-uncorrected.
- R3: A write (`wr_en` high) adds the unsigned value in `wr_data[2k+1:2k]` to counter k.
- R4: A write subtracts the unsigned value in `wr_data[8+2k+1:8+2k]` from counter k.
- R5: A counter that would rise above 3 holds at 3.
- R6: A counter that would fall below 0 holds at 0.
- R7: An event, an add and a subtract on one counter in the same cycle are summed into one net change, and saturation is applied only to the result.
- R8: `rd_status[2k+1:2k]` and `rd_status[8+2k+1:8+2k]` both return counter k.
- R9: On any cycle with at least one `evt_hit` bit set, `err_group`, `err_type` and `err_bit` take the event's details on the next edge. On cycles with no event they hold their values.
- R10: `irq` is high exactly when at least one counter is non-zero.
- R11: A change to one counter leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_hit | input | 4 | One-cycle error event per class |
| evt_group | input | 16 | Group of the checker reporting the event |
| evt_type | input | 16 | Type code of the event |
| evt_bit | input | 16 | Bit position of the event |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Add fields in [7:0], clear fields in [15:8] |
| rd_status | output | 16 | Counts, in both the add and clear positions |
| err_group | output | 16 | Captured group of the latest event |
| err_type | output | 16 | Captured type of the latest event |
| err_bit | output | 16 | Captured bit of the latest event |
| irq | output | 1 | High while any count is non-zero |

## Verification
Each class is first stepped alone by event pulses. This separates a correct class index from a crossed one and shows that the other counters stay put. Adds and clears of 1, 2 and 3 are applied from different starting counts. Starting at 3 or at 0 shows whether a counter saturates or wraps. Combined patterns, such as an event plus a clear of 2 at a count of 3, or an add of 2 with a clear of 3 at a count of 1, give a different result when the net change is summed first than when each term is clamped on its own. Back-to-back events with different details, followed by idle cycles, show that the latest event wins and that the captured fields hold when nothing happens.

// File: rtl/ecc_pend_pkg.sv
package ecc_pend_pkg;
  localparam int NUM_CLASS = 4;

  // Net change applied once, then clamped to [0, max_val]
  function automatic int sat_step(input int cur, input int hw_inc,
                                  input int add_v, input int sub_v,
                                  input int max_val);
    int net;
    net = cur + hw_inc + add_v - sub_v;
    if (net > max_val) net = max_val;
    else if (net < 0) net = 0;
    return net;
  endfunction
endpackage

// File: rtl/pend_counter.sv
module pend_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic [CNT_W-1:0] sub_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             nonzero
);
  import ecc_pend_pkg::*;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] add_eff, sub_eff, cnt_d;

  assign add_eff = wr_en ? add_val : '0;
  assign sub_eff = wr_en ? sub_val : '0;

  always_comb begin
    cnt_d = CNT_W'(sat_step(int'(cnt_q), int'(hw_inc), int'(add_eff),
                            int'(sub_eff), CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero = |cnt_q;
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int INFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INFO_W-1:0] group_in,
  input  logic [INFO_W-1:0] type_in,
  input  logic [INFO_W-1:0] bit_in,
  output logic [INFO_W-1:0] group_q,
  output logic [INFO_W-1:0] type_q,
  output logic [INFO_W-1:0] bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      group_q <= '0;
      type_q  <= '0;
      bit_q   <= '0;
    end else if (load) begin
      group_q <= group_in;
      type_q  <= type_in;
      bit_q   <= bit_in;
    end
  end
endmodule

// File: rtl/ecc_pend_status.sv
module ecc_pend_status #(
  parameter int NUM_CLASS = ecc_pend_pkg::NUM_CLASS,
  parameter int CNT_W     = 2,
  parameter int INFO_W    = 16,
  localparam int HALF_W   = NUM_CLASS * CNT_W,
  localparam int REG_W    = 2 * HALF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CLASS-1:0] evt_hit,
  input  logic [INFO_W-1:0]    evt_group,
  input  logic [INFO_W-1:0]    evt_type,
  input  logic [INFO_W-1:0]    evt_bit,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_status,
  output logic [INFO_W-1:0]    err_group,
  output logic [INFO_W-1:0]    err_type,
  output logic [INFO_W-1:0]    err_bit,
  output logic                 irq
);
  logic [NUM_CLASS-1:0] cls_nonzero;
  logic [HALF_W-1:0]    counts;
  logic                 any_evt;

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
    pend_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_inc  (evt_hit[k]),
      .wr_en   (wr_en),
      .add_val (wr_data[k*CNT_W +: CNT_W]),
      .sub_val (wr_data[HALF_W + k*CNT_W +: CNT_W]),
      .cnt_q   (counts[k*CNT_W +: CNT_W]),
      .nonzero (cls_nonzero[k])
    );
  end

  assign any_evt = |evt_hit;

  err_capture #(.INFO_W(INFO_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (any_evt),
    .group_in (evt_group),
    .type_in  (evt_type),
    .bit_in   (evt_bit),
    .group_q  (err_group),
    .type_q   (err_type),
    .bit_q    (err_bit)
  );

  assign rd_status = {counts, counts};
  assign irq       = |cls_nonzero;
endmodule

// File: rtl/ecc_pend_status_chk.sv
module ecc_pend_status_chk #(
  parameter int NUM_CLASS = 4,
  parameter int CNT_W     = 2,
  parameter int INFO_W    = 16,
  localparam int HALF_W   = NUM_CLASS * CNT_W,
  localparam int REG_W    = 2 * HALF_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CLASS-1:0] evt_hit,
  input logic [INFO_W-1:0]    evt_group,
  input logic [INFO_W-1:0]    evt_type,
  input logic [INFO_W-1:0]    evt_bit,
  input logic                 wr_en,
  input logic [REG_W-1:0]     wr_data,
  input logic [REG_W-1:0]     rd_status,
  input logic [INFO_W-1:0]    err_group,
  input logic [INFO_W-1:0]    err_type,
  input logic [INFO_W-1:0]    err_bit,
  input logic                 irq,
  input logic [NUM_CLASS-1:0] cls_nonzero
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (rd_status == '0 && !irq)));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_hit) |=> (err_group == $past(evt_group) && err_type == $past(evt_type)
                    && err_bit == $past(evt_bit)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|evt_hit) |=> ($stable(err_group) && $stable(err_type) && $stable(err_bit)));

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|evt_hit) && !wr_en) |=> $stable(rd_status));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|cls_nonzero));

  a_r2_event_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit[0] && !wr_en) |=>
      (rd_status[CNT_W-1:0] != '0 && rd_status[CNT_W-1:0] >= $past(rd_status[CNT_W-1:0])));

  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status[CNT_W-1:0] == CNT_W'(CNT_MAX) && !(wr_en && wr_data[HALF_W +: CNT_W] != '0))
      |=> rd_status[CNT_W-1:0] == CNT_W'(CNT_MAX));

  a_r6_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status[CNT_W-1:0] == '0 && !evt_hit[0] && !(wr_en && wr_data[CNT_W-1:0] != '0))
      |=> rd_status[CNT_W-1:0] == '0);
endmodule

bind ecc_pend_status ecc_pend_status_chk #(
  .NUM_CLASS(NUM_CLASS), .CNT_W(CNT_W), .INFO_W(INFO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_group(evt_group),
  .evt_type(evt_type), .evt_bit(evt_bit), .wr_en(wr_en), .wr_data(wr_data),
  .rd_status(rd_status), .err_group(err_group), .err_type(err_type),
  .err_bit(err_bit), .irq(irq), .cls_nonzero(cls_nonzero)
);

// File: tb/test_ecc_pend_status.sv
module test_ecc_pend_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_hit = '0;
  logic [15:0] evt_group = '0, evt_type = '0, evt_bit = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_status, err_group, err_type, err_bit;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  int model [4];
  logic [15:0] m_grp = '0, m_typ = '0, m_bit = '0;

  always #2 clk = ~clk;

  ecc_pend_status i_ecc_pend_status (
    .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_group(evt_group),
    .evt_type(evt_type), .evt_bit(evt_bit), .wr_en(wr_en), .wr_data(wr_data),
    .rd_status(rd_status), .err_group(err_group), .err_type(err_type),
    .err_bit(err_bit), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit any_nz;
    any_nz = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk({tag, " count"}, int'(rd_status[2*k +: 2]), model[k]);
      chk({tag, " R8 mirror"}, int'(rd_status[8 + 2*k +: 2]), model[k]);
      if (model[k] != 0) any_nz = 1'b1;
    end
    chk({tag, " R10 irq"}, int'(irq), int'(any_nz));
    chk({tag, " R9 group"}, int'(err_group), int'(m_grp));
    chk({tag, " R9 type"}, int'(err_type), int'(m_typ));
    chk({tag, " R9 bit"}, int'(err_bit), int'(m_bit));
  endtask

  // One cycle of stimulus, model update, then check after the edge
  task automatic step(input string tag, input logic [3:0] ev, input logic we,
                      input logic [15:0] d, input logic [15:0] g,
                      input logic [15:0] t, input logic [15:0] b);
    @(negedge clk);
    evt_hit = ev; wr_en = we; wr_data = d;
    evt_group = g; evt_type = t; evt_bit = b;
    for (int k = 0; k < 4; k++) begin
      int v;
      v = model[k];
      if (ev[k]) v = v + 1;
      if (we) v = v + int'(d[2*k +: 2]) - int'(d[8 + 2*k +: 2]);
      model[k] = (v < 0) ? 0 : ((v > 3) ? 3 : v);
    end
    if (ev != 4'b0) begin m_grp = g; m_typ = t; m_bit = b; end
    @(negedge clk);
    evt_hit = '0; wr_en = 1'b0; wr_data = '0;
    evt_group = 16'hdead; evt_type = 16'hbeef; evt_bit = 16'h5a5a;
    check_all(tag);
  endtask

  task automatic t_reset;
    check_all("R1 reset");
  endtask

  task automatic t_events;
    for (int k = 0; k < 4; k++) step("R2 R11 event", 4'(1 << k), 0, 0, 16'h10 + 16'(k), 16'h1, 16'(k));
    step("R2 all events", 4'hf, 0, 0, 16'h0007, 16'h0002, 16'h0021);
  endtask

  task automatic t_clear;
    step("R4 clear one", 0, 1, 16'h0100, 0, 0, 0);
    step("R4 R11 clear two", 0, 1, 16'h2000, 0, 0, 0);
    step("R6 floor", 0, 1, 16'hff00, 0, 0, 0);
    step("R6 floor again", 0, 1, 16'h0300, 0, 0, 0);
  endtask

  task automatic t_add;
    step("R3 add", 0, 1, 16'h00e4, 0, 0, 0);
    step("R5 saturate", 0, 1, 16'h00ff, 0, 0, 0);
    step("R5 event at max", 4'b0001, 0, 0, 16'h0a0a, 16'h3, 16'h40);
  endtask

  task automatic t_combine;
    step("R7 event plus clear two at max", 4'b0001, 1, 16'h0200, 16'h0b, 16'h4, 16'h41);
    step("R7 clear all", 0, 1, 16'hff00, 0, 0, 0);
    step("R7 setup", 0, 1, 16'h0001, 0, 0, 0);
    step("R7 add two clear three", 0, 1, 16'h0302, 0, 0, 0);
    step("R7 event add clear one", 4'b0100, 1, 16'h1010, 16'h0c, 16'h5, 16'h42);
  endtask

  task automatic t_capture;
    step("R9 first", 4'b1000, 0, 0, 16'h1234, 16'h0001, 16'h00ab);
    step("R9 latest wins", 4'b0010, 0, 0, 16'h8765, 16'h0002, 16'h0cd1);
    @(negedge clk); @(negedge clk);
    check_all("R9 held idle");
    step("R10 drain", 0, 1, 16'hff00, 0, 0, 0);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_events();
    t_clear();
    t_add();
    t_combine();
    t_capture();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule